// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

This unit sits beside the program counter in the fetch stage and decides which address to fetch next. It looks up the current fetch address in a small direct-mapped table. Each table entry holds a valid flag, an address tag, a stored jump destination and a two-bit confidence counter. If the address hits an entry whose counter leans toward "taken", the stored destination becomes the next fetch address. In every other case the next address is the fetch address plus four.

A later pipeline stage resolves each branch and reports back on a separate update port. It sends the branch address, whether the branch was actually taken, the real destination, and a flag saying the earlier guess was wrong. The table learns from these reports. The two-bit counter adds hysteresis: a branch must go against its prediction twice in a row before the predicted direction changes. As a result, a loop branch costs only one wrong guess each time the loop exits.

Top module: `fetch_next_pc_predictor`

## Requirements
- R1: After a cycle with `rst_n` low at a rising edge, every entry is empty: `pred_taken` is 0 and `pred_npc` equals `fetch_pc + 4` for any address.
- R2: When `pred_taken` is 0, `pred_npc` is `fetch_pc + 4`. When it is 1, `pred_npc` is the stored destination of the hit entry.
- R3: The entry is selected by address bits [5:2], giving 16 entries. Bits [1:0] are ignored. Bits [31:6] form the tag, and a different tag at the same entry is a miss.
- R4: A taken update that misses writes the entry (valid, new tag, destination). This replaces any older owner of the entry and sets its counter to 2. The address predicts taken to that destination from the next cycle on.
- R5: A not-taken update that misses changes nothing in the table.
- R6: On a hit, an update moves the counter up by one for taken and down by one for not taken. The counter saturates at 0 and at 3. Values 2 and 3 predict taken; values 0 and 1 predict not taken.
- R7: A branch in a strongly held state needs two consecutive opposite outcomes before its predicted direction changes.
- R8: On a hit, the stored destination is rewritten only when the update is taken and `upd_mispredict` is 1. A taken hit without the misprediction flag keeps the old destination.
- R9: If a lookup and an update address the same entry in the same cycle, the lookup sees the contents from before the update. The update takes effect for lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_npc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | 1 when the prediction comes from a stored destination |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | 32 | Actual destination of the resolved branch |
| upd_mispredict | input | 1 | The earlier prediction for this branch was wrong |

## Verification
The assertions check several rules on every cycle:
- the empty table right after reset;
- the fall-through address whenever no taken prediction is made;
- the immediate taken prediction after a taken branch allocates an entry;
- the absence of any prediction after a not-taken branch misses.

Other behaviour only shows up in directed sequences, which the bench drives against a behavioural model: counter saturation at both ends, the two-miss hysteresis, entry eviction by a different tag, the rule for rewriting destinations, and the old-contents result when a lookup and an update hit the same entry in the same cycle.

// File: rtl/npc_pred_pkg.sv
// Shared types for the next-PC predictor.
// Assumes a two-bit confidence counter whose upper bit gives the direction.
package npc_pred_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_t;

endpackage

// File: rtl/npc_ctr_step.sv
// Saturating step of one confidence counter.
// Taken moves the counter up and not taken moves it down; it stops at both ends.
// An update that misses loads the weakly-taken value instead.
module npc_ctr_step
    import npc_pred_pkg::*;
(
    input  ctr_t cur,
    input  logic hit,
    input  logic taken,
    output ctr_t nxt
);

    // next counter value for the addressed entry
    always_comb begin
        if (!hit) begin
            nxt = CTR_WEAK_T;
        end else if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? CTR_STRONG_T : ctr_t'(cur + 2'd1);
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? CTR_STRONG_NT : ctr_t'(cur - 2'd1);
        end
    end

endmodule

// File: rtl/npc_table.sv
// Direct-mapped entry storage: valid, tag, destination and counter for each entry.
// Has two combinational read ports (lookup and update) and one synchronous write.
// Reads return the registered state, so a same-cycle write shows up only one cycle later.
// Reset clears the valid bits and counters. Destinations and tags are not reset.
module npc_table
    import npc_pred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int TAG_W = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt,
    output ctr_t             rd_ctr,
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_valid,
    output logic [TAG_W-1:0] up_tag,
    output ctr_t             up_ctr,
    input  logic             wr_en,
    input  logic             wr_tgt_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  ctr_t             wr_ctr
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];
    ctr_t               ctr_q [ENTRIES];

    // valid flag and counter state, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                ctr_q[e] <= CTR_STRONG_NT;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            ctr_q[wr_idx]   <= wr_ctr;
        end
    end

    // tag and destination payload, not reset
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
        if (rst_n && wr_tgt_en) begin
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // lookup read port
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
        rd_ctr   = ctr_q[rd_idx];
    end

    // update read port
    always_comb begin
        up_valid = valid_q[up_idx];
        up_tag   = tag_q[up_idx];
        up_ctr   = ctr_q[up_idx];
    end

endmodule

// File: rtl/npc_select.sv
// Hit detection and next-address choice for the fetch address.
// A hit needs a valid entry with a matching tag. The prediction is taken when
// the counter's upper bit is set; otherwise the sequential address is used.
module npc_select
    import npc_pred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = PC_W - 6
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_tgt,
    input  ctr_t             ent_ctr,
    output logic [PC_W-1:0]  npc,
    output logic             taken
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic hit;

    // compare tag and choose the next address
    always_comb begin
        hit   = ent_valid && (ent_tag == pc[PC_W-1 -: TAG_W]);
        taken = hit && ent_ctr[1];
        npc   = taken ? ent_tgt : pc + STEP;
    end

endmodule

// File: rtl/fetch_next_pc_predictor.sv
// Top of the next-PC predictor.
// A lookup indexes the table with address bits [IDX_W+1:2] and compares the upper bits as a tag.
// The update port applies one resolved branch per cycle: a counter step on a hit,
// an allocation on a taken miss, and a destination rewrite on a mispredicted taken hit.
// Assumes at most one update per cycle and word-aligned instruction addresses.
module fetch_next_pc_predictor
    import npc_pred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] pred_npc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_mispredict
);

    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0] rd_idx, up_idx;
    logic [TAG_W-1:0] up_tag_in;
    logic             rd_valid, up_valid;
    logic [TAG_W-1:0] rd_tag, up_tag;
    logic [PC_W-1:0]  rd_tgt;
    ctr_t             rd_ctr, up_ctr, ctr_new;
    logic             upd_hit;
    logic             wr_en, wr_tgt_en;

    // split both addresses into index and tag
    always_comb begin
        rd_idx    = fetch_pc[IDX_W+1:2];
        up_idx    = upd_pc[IDX_W+1:2];
        up_tag_in = upd_pc[PC_W-1 -: TAG_W];
    end

    // decide what the resolved branch writes
    always_comb begin
        upd_hit   = up_valid && (up_tag == up_tag_in);
        wr_en     = upd_valid && (upd_hit || upd_taken);
        wr_tgt_en = upd_valid && upd_taken && (!upd_hit || upd_mispredict);
    end

    npc_ctr_step ctr_i (
        .cur   (up_ctr),
        .hit   (upd_hit),
        .taken (upd_taken),
        .nxt   (ctr_new)
    );

    npc_table #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_tgt    (rd_tgt),
        .rd_ctr    (rd_ctr),
        .up_idx    (up_idx),
        .up_valid  (up_valid),
        .up_tag    (up_tag),
        .up_ctr    (up_ctr),
        .wr_en     (wr_en),
        .wr_tgt_en (wr_tgt_en),
        .wr_idx    (up_idx),
        .wr_tag    (up_tag_in),
        .wr_tgt    (upd_target),
        .wr_ctr    (ctr_new)
    );

    npc_select #(.PC_W(PC_W), .TAG_W(TAG_W)) sel_i (
        .pc        (fetch_pc),
        .ent_valid (rd_valid),
        .ent_tag   (rd_tag),
        .ent_tgt   (rd_tgt),
        .ent_ctr   (rd_ctr),
        .npc       (pred_npc),
        .taken     (pred_taken)
    );

endmodule

// File: rtl/npc_pred_checker.sv
// Property checker for the next-PC predictor, attached to the top by bind.
// Watches the ports plus the update hit flag of the top.
module npc_pred_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic [PC_W-1:0] pred_npc,
    input logic            pred_taken,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_hit
);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pred_taken); // R1

    AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_npc == fetch_pc + PC_W'(4)); // R2

    AST_ALLOC_PREDICTS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && !upd_hit) |=>
        (fetch_pc != $past(upd_pc)) || (pred_taken && pred_npc == $past(upd_target))); // R4

    AST_NT_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !upd_hit) |=>
        (fetch_pc != $past(upd_pc)) || !pred_taken); // R5

endmodule

bind fetch_next_pc_predictor npc_pred_checker #(.PC_W(PC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .pred_npc   (pred_npc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_target (upd_target),
    .upd_hit    (upd_hit)
);

// File: tb/fetch_next_pc_predictor_tb.sv
// Bench for the next-PC predictor: a behavioural model is compared every clock.
module fetch_next_pc_predictor_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] pred_npc;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_mispredict = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit model_ready = 0;

    // behavioural model state, one slot per index value
    bit          m_valid [16];
    logic [25:0] m_tag   [16];
    logic [31:0] m_dest  [16];
    int          m_conf  [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_next_pc_predictor dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .pred_npc       (pred_npc),
        .pred_taken     (pred_taken),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_target     (upd_target),
        .upd_mispredict (upd_mispredict)
    );

    task automatic step(input logic rst, input logic [31:0] fpc,
                        input logic uv, input logic [31:0] upc, input logic ut,
                        input logic [31:0] utgt, input logic um, input string req);
        int          fi, ui;
        bit          fhit, uhit, exp_tk;
        logic [31:0] exp_npc;
        @(negedge clk);
        rst_n = rst; fetch_pc = fpc; upd_valid = uv; upd_pc = upc;
        upd_taken = ut; upd_target = utgt; upd_mispredict = um;
        #1;
        if (model_ready) begin
            fi      = int'(fpc[5:2]);
            fhit    = m_valid[fi] && (m_tag[fi] == fpc[31:6]);
            exp_tk  = fhit && (m_conf[fi] >= 2);
            exp_npc = exp_tk ? m_dest[fi] : fpc + 32'd4;
            n_vec++;
            if (pred_taken !== exp_tk || pred_npc !== exp_npc) begin
                n_bad++;
                $display("FAIL %s pc=%h: got taken=%b npc=%h, expected taken=%b npc=%h",
                         req, fpc, pred_taken, pred_npc, exp_tk, exp_npc);
            end
        end
        @(posedge clk);
        if (!rst) begin
            for (int e = 0; e < 16; e++) begin
                m_valid[e] = 0;
                m_conf[e] = 0;
            end
            model_ready = 1;
        end else if (uv) begin
            ui   = int'(upc[5:2]);
            uhit = m_valid[ui] && (m_tag[ui] == upc[31:6]);
            if (uhit) begin
                if (ut && m_conf[ui] < 3) m_conf[ui]++;
                if (!ut && m_conf[ui] > 0) m_conf[ui]--;
                if (ut && um) m_dest[ui] = utgt;
            end else if (ut) begin
                m_valid[ui] = 1; m_tag[ui] = upc[31:6];
                m_dest[ui] = utgt; m_conf[ui] = 2;
            end
        end
    endtask

    task automatic look(input logic [31:0] fpc, input string req);
        step(1'b1, fpc, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, req);
    endtask

    task automatic upd(input logic [31:0] fpc, input logic [31:0] upc, input logic ut,
                       input logic [31:0] utgt, input logic um, input string req);
        step(1'b1, fpc, 1'b1, upc, ut, utgt, um, req);
    endtask

    localparam logic [31:0] PA  = 32'h0000_1048;  // index 2
    localparam logic [31:0] PA2 = 32'h0000_2048;  // index 2, other tag
    localparam logic [31:0] PB  = 32'h0000_3050;  // index 4
    localparam logic [31:0] T1  = 32'h0000_4000;
    localparam logic [31:0] T2  = 32'h0000_5000;

    initial begin
        step(1'b0, PA, 1'b0, 0, 0, 0, 0, "R1");
        step(1'b0, PA, 1'b0, 0, 0, 0, 0, "R1");
        look(PA, "R1 empty after reset");
        look(PB, "R1 empty after reset");
        // R4 allocation, lookup on another entry in the same cycle
        upd(PB, PA, 1'b1, T1, 1'b1, "R4");
        look(PA, "R4 allocated weakly taken");
        look(PA, "R2 stored destination");
        // R9 lookup sees old contents during update
        upd(PA, PA, 1'b0, 0, 1'b1, "R9 old contents");
        look(PA, "R6 down to weak not taken");
        upd(PA, PA, 1'b1, T1, 1'b1, "R9 old contents");
        look(PA, "R6 back to weak taken");
        // R3 index and tag split
        look(PA | 32'h3, "R3 low bits ignored");
        look(PA2, "R3 tag mismatch misses");
        // R6 / R7 saturation and hysteresis
        upd(PB, PA, 1'b1, T1, 1'b0, "R6");
        upd(PB, PA, 1'b1, T1, 1'b0, "R6");
        look(PA, "R6 saturate high");
        upd(PB, PA, 1'b0, 0, 1'b1, "R7");
        look(PA, "R7 one miss keeps taken");
        upd(PB, PA, 1'b0, 0, 1'b1, "R7");
        look(PA, "R7 second miss flips");
        upd(PB, PA, 1'b0, 0, 1'b0, "R6");
        upd(PB, PA, 1'b0, 0, 1'b0, "R6");
        upd(PB, PA, 1'b0, 0, 1'b0, "R6");
        look(PA, "R6 saturate low");
        upd(PB, PA, 1'b1, T1, 1'b1, "R6");
        look(PA, "R6 one taken from zero stays not taken");
        upd(PB, PA, 1'b1, T1, 1'b1, "R6");
        look(PA, "R7 second taken flips");
        // R8 destination rewrite rule
        upd(PB, PA, 1'b1, T2, 1'b0, "R8");
        look(PA, "R8 no rewrite without mispredict");
        upd(PB, PA, 1'b1, T2, 1'b1, "R8");
        look(PA, "R8 rewrite on mispredict");
        // R4 eviction by another tag
        upd(PB, PA2, 1'b1, T1, 1'b1, "R4");
        look(PA2, "R4 new owner predicts");
        look(PA, "R4 old owner evicted");
        // R5 not-taken miss
        upd(PB, PB, 1'b0, T2, 1'b1, "R5");
        look(PB, "R5 no allocation");
        look(PB, "R5 no allocation");
        // R1 reset again
        step(1'b0, PA2, 1'b0, 0, 0, 0, 0, "R1");
        look(PA2, "R1 cleared by reset");
        look(PB, "R1 cleared by reset");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule